// File: doc/BRIEF.md
# Four-Bit Key Input Port with Combined Interrupt

This block is the front end of a small input-only port for a microcontroller. It takes four pin levels from the pads and passes them through a two-flop synchronizer. It presents the result to software as a read-only level register on a simple register bus. Two mode registers together give each pin a two-bit pad code that selects pull-up, pull-down or no pull. The block drives the matching pull-control outputs towards the pad.

An enable register picks which synchronized pins take part in one shared interrupt. That interrupt watches the OR of the enabled pins. When the OR rises, it emits a one-cycle request and sets a pending flag, which software reads and clears through the bus.

Top module: `keyin_port`

## Requirements
- R1: A read at offset 0x0 returns the synchronized pin levels in bits 3..0, where bit i is pin i, 1 means high and 0 means low. A change on a pin becomes visible on the second rising clock edge after it, and the upper read bits are 0.
- R2: Reset gives the following state. Offset 0x0 reads 0, both mode registers and the enable register read 0, the pending flag reads 0, all pull-up and pull-down outputs are 0 and the interrupt output is 0.
- R3: Offset 0x1 holds the low mode bit of each pin and offset 0x2 holds the high mode bit. For pin i the code {high[i], low[i]} means the following: 00 gives no pull, 01 drives pull_up_o[i]=1, 10 drives pull_down_o[i]=1, and 11 gives no pull. The outputs follow a write from the next clock edge, and both registers read back what was written.
- R4: Offset 0x3 holds one interrupt-enable bit per pin and reads back what was written. A pin whose enable bit is 0 never causes an interrupt.
- R5: irq_o is a one-cycle pulse. It fires on the clock edge after the OR of the enabled synchronized pins goes from 0 to 1, which is the third edge after the pin changes. An OR that stays high gives no further pulse. Enabling a pin that is already high counts as a rising OR.
- R6: Offset 0x4 bit 0 is the pending flag. Each irq_o pulse sets it, and it stays set until a write to 0x4 with bit 0 = 1. A write with bit 0 = 0 leaves it unchanged. If a set and a clear fall on the same edge, the set wins.
- R7: A write to offset 0x0 changes nothing: the mode, enable and pending state and the pad outputs keep their values.
- R8: A read of an unused offset, or any read with reg_sel_i low, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Raw pin levels from the pads |
| reg_sel_i | input | 1 | Register access select |
| reg_wr_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| pull_up_o | output | 4 | Per-pin pull-up enable to the pad |
| pull_down_o | output | 4 | Per-pin pull-down enable to the pad |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with its default values: four pins, two synchronizer stages, an 8-bit data bus and a 4-bit offset. Four pins are few enough to sweep completely. The bench runs every level pattern through the read path, all 256 combinations of the two mode registers against the pull outputs, and every pairing of the 16 enable masks with the 16 pin patterns against the interrupt pulse and the pending flag. With two stages the latency is small and fixed, so the bench can time a pending clear to land on the same edge as a new request.

// File: rtl/keyin_pkg.sv
package keyin_pkg;

    typedef enum logic [1:0] {
        PULL_NONE     = 2'b00,
        PULL_UP       = 2'b01,
        PULL_DOWN     = 2'b10,
        PULL_NONE_ALT = 2'b11
    } pull_mode_e;

    localparam int unsigned OFS_LEVEL   = 0;
    localparam int unsigned OFS_MODE_LO = 1;
    localparam int unsigned OFS_MODE_HI = 2;
    localparam int unsigned OFS_IRQ_EN  = 3;
    localparam int unsigned OFS_PEND    = 4;

endpackage

// File: rtl/keyin_sync.sv
module keyin_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = pin_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign level_o = s_q.chain[STAGES-1];

    // R1: the first stage captures the pin value of the previous edge
    a_r1_first_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> s_q.chain[0] == $past(pin_i));

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
            // R1: each later stage delays the one before it by one edge
            a_r1_stage_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $past(rst_ni) |-> s_q.chain[g] == $past(s_q.chain[g-1]));
        end
    endgenerate

endmodule

// File: rtl/keyin_regs.sv
module keyin_regs
    import keyin_pkg::*;
#(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [WIDTH-1:0]  level_i,
    input  logic              pend_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [WIDTH-1:0]  mode_lo_o,
    output logic [WIDTH-1:0]  mode_hi_o,
    output logic [WIDTH-1:0]  irq_en_o,
    output logic              pend_clr_o
);

    localparam logic [ADDR_W-1:0] A_LEVEL   = ADDR_W'(OFS_LEVEL);
    localparam logic [ADDR_W-1:0] A_MODE_LO = ADDR_W'(OFS_MODE_LO);
    localparam logic [ADDR_W-1:0] A_MODE_HI = ADDR_W'(OFS_MODE_HI);
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = ADDR_W'(OFS_IRQ_EN);
    localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFS_PEND);

    typedef struct packed {
        logic [WIDTH-1:0] mode_lo;
        logic [WIDTH-1:0] mode_hi;
        logic [WIDTH-1:0] irq_en;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_hit;

    assign wr_hit = sel_i & wr_i;

    always_comb begin
        r_d = r_q;
        pend_clr_o = 1'b0;
        if (wr_hit) begin
            unique case (addr_i)
                A_MODE_LO: r_d.mode_lo = wdata_i[WIDTH-1:0];
                A_MODE_HI: r_d.mode_hi = wdata_i[WIDTH-1:0];
                A_IRQ_EN:  r_d.irq_en  = wdata_i[WIDTH-1:0];
                A_PEND:    pend_clr_o  = wdata_i[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            unique case (addr_i)
                A_LEVEL:   rdata_o = DATA_W'(level_i);
                A_MODE_LO: rdata_o = DATA_W'(r_q.mode_lo);
                A_MODE_HI: rdata_o = DATA_W'(r_q.mode_hi);
                A_IRQ_EN:  rdata_o = DATA_W'(r_q.irq_en);
                A_PEND:    rdata_o = DATA_W'(pend_i);
                default:   rdata_o = '0;
            endcase
        end
    end

    generate
        if (DATA_W > WIDTH) begin : g_wide
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata_i[DATA_W-1:WIDTH];
        end
    endgenerate

    assign mode_lo_o = r_q.mode_lo;
    assign mode_hi_o = r_q.mode_hi;
    assign irq_en_o  = r_q.irq_en;

    // R3: a write to the low mode register shows on its output next edge
    a_r3_mode_lo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == A_MODE_LO) |=> mode_lo_o == $past(wdata_i[WIDTH-1:0]));

    // R4: a write to the enable register shows on its output next edge
    a_r4_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == A_IRQ_EN) |=> irq_en_o == $past(wdata_i[WIDTH-1:0]));

    // R7: a write to the level offset leaves all held state alone
    a_r7_level_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == A_LEVEL) |=> $stable(r_q));

endmodule

// File: rtl/keyin_pad_ctrl.sv
module keyin_pad_ctrl
    import keyin_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] mode_lo_i,
    input  logic [WIDTH-1:0] mode_hi_i,
    output logic [WIDTH-1:0] pull_up_o,
    output logic [WIDTH-1:0] pull_down_o
);

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            pull_mode_e mode;
            assign mode = pull_mode_e'({mode_hi_i[g], mode_lo_i[g]});
            assign pull_up_o[g]   = (mode == PULL_UP);
            assign pull_down_o[g] = (mode == PULL_DOWN);
        end
    endgenerate

endmodule

// File: rtl/keyin_irq.sv
module keyin_irq #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic             clr_i,
    output logic             irq_o,
    output logic             pend_o
);

    typedef struct packed {
        logic any;
        logic irq;
        logic pend;
    } irq_t;

    irq_t i_d, i_q;
    logic any_now;
    logic rise;

    assign any_now = |(level_i & en_i);
    assign rise    = any_now & ~i_q.any;

    always_comb begin
        i_d = i_q;
        i_d.any  = any_now;
        i_d.irq  = rise;
        i_d.pend = rise | (i_q.pend & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) i_q <= '0;
        else         i_q <= i_d;
    end

    assign irq_o  = i_q.irq;
    assign pend_o = i_q.pend;

    // R5: a request never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    // R5: no request while every enabled pin was low a cycle earlier
    a_r5_needs_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past((level_i & en_i) != '0));

    // R6: a request always leaves the pending flag set
    a_r6_pend_on_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> pend_o);

    // R6: pending only drops after a clear strobe
    a_r6_pend_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pend_o) |-> $past(clr_i));

endmodule

// File: rtl/keyin_port.sv
module keyin_port #(
    parameter int unsigned WIDTH       = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WIDTH-1:0]  pin_i,
    input  logic              reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [WIDTH-1:0]  pull_up_o,
    output logic [WIDTH-1:0]  pull_down_o,
    output logic              irq_o
);

    logic [WIDTH-1:0] level;
    logic [WIDTH-1:0] mode_lo;
    logic [WIDTH-1:0] mode_hi;
    logic [WIDTH-1:0] irq_en;
    logic             pend;
    logic             pend_clr;

    keyin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .level_o (level)
    );

    keyin_regs #(.WIDTH(WIDTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sel_i      (reg_sel_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .level_i    (level),
        .pend_i     (pend),
        .rdata_o    (reg_rdata_o),
        .mode_lo_o  (mode_lo),
        .mode_hi_o  (mode_hi),
        .irq_en_o   (irq_en),
        .pend_clr_o (pend_clr)
    );

    keyin_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
        .mode_lo_i   (mode_lo),
        .mode_hi_i   (mode_hi),
        .pull_up_o   (pull_up_o),
        .pull_down_o (pull_down_o)
    );

    keyin_irq #(.WIDTH(WIDTH)) u_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (level),
        .en_i    (irq_en),
        .clr_i   (pend_clr),
        .irq_o   (irq_o),
        .pend_o  (pend)
    );

    // R3: a pin is never pulled both ways at once
    a_r3_pull_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pull_up_o & pull_down_o) == '0);

    // R7: a write to the level offset leaves the pad outputs unchanged
    a_r7_pads_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_sel_i && reg_wr_i && reg_addr_i == '0) |=> ($stable(pull_up_o) && $stable(pull_down_o)));

endmodule

// File: tb/test_keyin_port.sv
module test_keyin_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = '0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] pu, pd;
    logic       irq;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    keyin_port i_keyin_port (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
        .reg_sel_i(sel), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .pull_up_o(pu), .pull_down_o(pd), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 irq", irq, 0);
        check("R2 pull_up", pu, 0);
        check("R2 pull_down", pd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 5; a++) begin
            reg_read(a[3:0], rv);
            check("R2 reg", rv, 0);
        end

        // R8: unused offsets and deselected reads
        for (int a = 5; a < 16; a++) begin
            reg_read(a[3:0], rv);
            check("R8 unused", rv, 0);
        end

        // R1: every level pattern, with latency
        for (int p = 0; p < 16; p++) begin
            logic [3:0] prev;
            prev = pin;
            pin = p[3:0];
            @(negedge clk);
            reg_read(4'h0, rv);
            check("R1 old level", rv, {4'h0, prev});
            @(negedge clk);
            reg_read(4'h0, rv);
            check("R1 level", rv, {4'h0, p[3:0]});
            sel = 1'b1; wr = 1'b0; addr = 4'h0;
            #1 check("R8 upper bits", rdata[7:4], 0);
            sel = 1'b0;
        end

        // R3: all combinations of the two mode registers
        for (int v = 0; v < 256; v++) begin
            logic [3:0] lo, hi;
            lo = v[3:0]; hi = v[7:4];
            reg_write(4'h1, {4'h0, lo});
            reg_write(4'h2, {4'h0, hi});
            check("R3 pull_up", pu, ~hi & lo);
            check("R3 pull_down", pd, hi & ~lo);
            if (v % 17 == 0) begin
                reg_read(4'h1, rv); check("R3 lo readback", rv, {4'h0, lo});
                reg_read(4'h2, rv); check("R3 hi readback", rv, {4'h0, hi});
            end
        end

        // R7: write to level offset changes nothing
        reg_write(4'h1, 8'h05);
        reg_write(4'h2, 8'h0A);
        reg_write(4'h3, 8'h09);
        pin = 4'hF;
        repeat (4) @(negedge clk);
        reg_read(4'h4, rv);
        check("R7 setup pend", rv, 1);
        reg_write(4'h0, 8'hFF);
        reg_write(4'h0, 8'h00);
        check("R7 pull_up", pu, 4'h5);
        check("R7 pull_down", pd, 4'hA);
        reg_read(4'h3, rv); check("R7 enable", rv, 8'h09);
        reg_read(4'h4, rv); check("R7 pend", rv, 1);
        reg_read(4'h0, rv); check("R7 level", rv, 8'h0F);
        pin = 4'h0;
        reg_write(4'h3, 8'h00);
        reg_write(4'h4, 8'h01);
        repeat (4) @(negedge clk);

        // R4 R5 R6: every enable mask against every pin pattern
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 16; p++) begin
                logic exp;
                exp = |(e[3:0] & p[3:0]);
                reg_write(4'h3, {4'h0, e[3:0]});
                reg_read(4'h3, rv);
                check("R4 enable readback", rv, {4'h0, e[3:0]});
                reg_write(4'h4, 8'h01);
                pin = p[3:0];
                @(negedge clk);
                @(negedge clk);
                check("R5 early", irq, 0);
                @(negedge clk);
                check("R4 R5 pulse", irq, exp);
                @(negedge clk);
                check("R5 one cycle", irq, 0);
                repeat (2) @(negedge clk);
                check("R5 no retrigger", irq, 0);
                reg_read(4'h4, rv);
                check("R6 pend set", rv, {7'h0, exp});
                reg_write(4'h4, 8'h00);
                reg_read(4'h4, rv);
                check("R6 write zero keeps", rv, {7'h0, exp});
                reg_write(4'h4, 8'h01);
                reg_read(4'h4, rv);
                check("R6 cleared", rv, 0);
                pin = 4'h0;
                repeat (4) @(negedge clk);
            end
        end

        // R5: enabling a pin that is already high
        reg_write(4'h3, 8'h00);
        pin = 4'h4;
        repeat (4) @(negedge clk);
        reg_write(4'h3, 8'h04);
        check("R5 before enable edge", irq, 0);
        @(negedge clk);
        check("R5 enable while high", irq, 1);
        @(negedge clk);
        check("R5 enable one cycle", irq, 0);
        reg_write(4'h4, 8'h01);
        pin = 4'h0;
        repeat (4) @(negedge clk);

        // R6: set wins over clear on the same edge
        pin = 4'h4;
        @(negedge clk);
        @(negedge clk);
        reg_write(4'h4, 8'h01);
        reg_read(4'h4, rv);
        check("R6 set beats clear", rv, 1);
        reg_write(4'h4, 8'h01);
        reg_read(4'h4, rv);
        check("R6 later clear", rv, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule